// File: doc/BRIEF.md
# Accumulator and Flag Update Unit

This unit produces the new accumulator value, a 16-bit wide result and the packed condition-flag byte for a small group of 8-bit processor operations. The operations are: OR of an operand into the accumulator, bitwise inversion of the accumulator, forcing the carry flag, toggling the carry flag, and adding a signed 8-bit displacement to the 16-bit stack pointer. The execute stage presents the operation code, the accumulator, the operand byte, the stack pointer and the current flag byte. On a cycle where the enable is high, the unit captures its results in output registers. The outputs appear one clock after the enabled edge.

The displacement add is modelled on the stack-pointer-relative load. The 16-bit sum uses the sign-extended displacement. The half-carry and carry flags, however, come from unsigned sums of the low nibble and the low byte of the two operands, and not from the 16-bit result.

Top module: `cpu_flag_unit`

## Requirements
- R1: Operation code 0 (OR) loads `acc_in | operand` into the accumulator. It sets Z when that 8-bit result is zero and clears N, H and C.
- R2: Operation code 1 (invert) loads the bitwise complement of `acc_in` and sets N and H. Z and C are copied from `flags_in`, even when the complement is zero.
- R3: Operation code 2 (set carry) sets C and clears N and H. Z is copied from `flags_in`, and the accumulator output takes `acc_in` unchanged.
- R4: Operation code 3 (toggle carry) sets C to the inverse of `flags_in` bit 4 and clears N and H. Z is copied from `flags_in`, and the accumulator output takes `acc_in`.
- R5: Operation code 4 (displacement add) loads `sp_in` plus the sign-extended `operand`, modulo 2^16, into `wide_out`. The accumulator output takes `acc_in`.
- R6: For operation code 4, Z and N are cleared. H is set when `sp_in[3:0] + operand[3:0]` exceeds 15. C is set when `sp_in[7:0] + operand` exceeds 255. Both sums are unsigned.
- R7: The flag byte holds Z in bit 7, N in bit 6, H in bit 5 and C in bit 4. Bits 3..0 of `flags_out` always read zero, and bits 3..0 of `flags_in` are ignored.
- R8: When `en` is low at a clock edge, `acc_out`, `wide_out` and `flags_out` keep their values whatever the other inputs do.
- R9: While `rst_n` is low, all three outputs are zero. This takes effect at once, without waiting for a clock edge.
- R10: Operation codes 5 to 7 change no output, even with `en` high.
- R11: `wide_out` changes only on an enabled displacement add. All other operations leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Capture enable for all result registers |
| op_sel | input | 3 | Operation code (0 OR, 1 invert, 2 set carry, 3 toggle carry, 4 displacement add) |
| acc_in | input | 8 | Current accumulator |
| operand | input | 8 | OR operand, or signed displacement for code 4 |
| sp_in | input | 16 | Current stack pointer |
| flags_in | input | 8 | Current flag byte, same packing as `flags_out` |
| acc_out | output | 8 | Registered accumulator result |
| wide_out | output | 16 | Registered 16-bit displacement-add result |
| flags_out | output | 8 | Registered flag byte |

## Verification
Every result sits exactly one register behind its inputs. Values driven before a rising edge with `en` high are due on the outputs right after that edge. The bench therefore drives on the falling edge and samples on the next falling edge. Reset is the one exception: it clears the outputs at once, so it is sampled a nanosecond after `rst_n` falls. The hold cases (enable low, unused codes, the wide register on 8-bit operations) are sampled one edge after the disturbing stimulus. At that point the old values must still be present.

// File: rtl/flgu_pkg.sv
package flgu_pkg;

  typedef enum logic [2:0] {
    OP_OR    = 3'd0,
    OP_INV   = 3'd1,
    OP_SETC  = 3'd2,
    OP_TOGC  = 3'd3,
    OP_SPADD = 3'd4
  } op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } flags_t;

  localparam int FLAG_BITS = 4;

endpackage

// File: rtl/flgu_logic8.sv
module flgu_logic8
  import flgu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [2:0]    op,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] opnd,
  input  flags_t        fin,
  output logic [DW-1:0] res,
  output flags_t        fout
);

  logic [DW-1:0] or_val;

  assign or_val = acc | opnd;

  always_comb begin
    res  = acc;
    fout = fin;
    case (op)
      OP_OR: begin
        res  = or_val;
        fout = '{z: (or_val == '0), n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_INV: begin
        res    = ~acc;
        fout.n = 1'b1;
        fout.h = 1'b1;
      end
      OP_SETC: begin
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = 1'b1;
      end
      OP_TOGC: begin
        fout.n = 1'b0;
        fout.h = 1'b0;
        fout.c = ~fin.c;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/flgu_spadd.sv
module flgu_spadd #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] sp,
  input  logic [OW-1:0] ofs,
  output logic [AW-1:0] sum,
  output logic          half_c,
  output logic          full_c
);

  localparam int EXT = AW - OW;
  localparam int NIB = OW / 2;

  logic [AW-1:0] ofs_ext;
  logic [NIB:0]  nib_sum;
  logic [OW:0]   byte_sum;

  assign ofs_ext  = {{EXT{ofs[OW-1]}}, ofs};
  assign sum      = sp + ofs_ext;
  assign nib_sum  = {1'b0, sp[NIB-1:0]} + {1'b0, ofs[NIB-1:0]};
  assign byte_sum = {1'b0, sp[OW-1:0]} + {1'b0, ofs};
  assign half_c   = nib_sum[NIB];
  assign full_c   = byte_sum[OW];

endmodule

// File: rtl/flgu_reg.sv
module flgu_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/cpu_flag_unit.sv
module cpu_flag_unit
  import flgu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [2:0]    op_sel,
  input  logic [DW-1:0] acc_in,
  input  logic [DW-1:0] operand,
  input  logic [AW-1:0] sp_in,
  input  logic [DW-1:0] flags_in,
  output logic [DW-1:0] acc_out,
  output logic [AW-1:0] wide_out,
  output logic [DW-1:0] flags_out
);

  localparam int PAD = DW - FLAG_BITS;

  flags_t        fin;
  flags_t        l8_flg;
  flags_t        flg_d;
  flags_t        flg_q;
  logic [DW-1:0] l8_res;
  logic [DW-1:0] acc_d;
  logic [AW-1:0] sp_sum;
  logic          sp_h;
  logic          sp_c;
  logic          ld_acc;
  logic          ld_wide;
  logic          ld_flg;
  logic          unused_low;

  assign fin        = flags_t'(flags_in[DW-1:PAD]);
  assign unused_low = ^flags_in[PAD-1:0];

  flgu_logic8 #(.DW(DW)) u_logic (
    .op   (op_sel),
    .acc  (acc_in),
    .opnd (operand),
    .fin  (fin),
    .res  (l8_res),
    .fout (l8_flg)
  );

  flgu_spadd #(.AW(AW), .OW(DW)) u_spadd (
    .sp     (sp_in),
    .ofs    (operand),
    .sum    (sp_sum),
    .half_c (sp_h),
    .full_c (sp_c)
  );

  always_comb begin
    ld_acc  = 1'b0;
    ld_wide = 1'b0;
    ld_flg  = 1'b0;
    acc_d   = acc_in;
    flg_d   = fin;
    if (en) begin
      case (op_sel)
        OP_OR, OP_INV, OP_SETC, OP_TOGC: begin
          ld_acc = 1'b1;
          ld_flg = 1'b1;
          acc_d  = l8_res;
          flg_d  = l8_flg;
        end
        OP_SPADD: begin
          ld_acc  = 1'b1;
          ld_wide = 1'b1;
          ld_flg  = 1'b1;
          flg_d   = '{z: 1'b0, n: 1'b0, h: sp_h, c: sp_c};
        end
        default: ;
      endcase
    end
  end

  flgu_reg #(.W(DW)) u_acc_q (
    .clk (clk), .rst_n (rst_n), .load (ld_acc), .d (acc_d), .q (acc_out)
  );

  flgu_reg #(.W(AW)) u_wide_q (
    .clk (clk), .rst_n (rst_n), .load (ld_wide), .d (sp_sum), .q (wide_out)
  );

  flgu_reg #(.W(FLAG_BITS)) u_flg_q (
    .clk (clk), .rst_n (rst_n), .load (ld_flg), .d (flg_d), .q (flg_q)
  );

  assign flags_out = {flg_q, {PAD{1'b0}}};

endmodule

// File: rtl/flgu_chk.sv
module flgu_chk
  import flgu_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [2:0]    op_sel,
  input logic [DW-1:0] acc_in,
  input logic [DW-1:0] operand,
  input logic [DW-1:0] flags_in,
  input logic [DW-1:0] acc_out,
  input logic [AW-1:0] wide_out,
  input logic [DW-1:0] flags_out
);

  AST_OR_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_OR) |=> (flags_out[DW-2:DW-4] == 3'b000)
      && (flags_out[DW-1] == ($past(acc_in | operand) == '0))); // R1

  AST_INV_NH: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_INV) |=> flags_out[DW-2] && flags_out[DW-3]
      && (acc_out == ~$past(acc_in))); // R2

  AST_SETC: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_SETC) |=> flags_out[DW-4] && !flags_out[DW-2]
      && !flags_out[DW-3] && (flags_out[DW-1] == $past(flags_in[DW-1]))); // R3

  AST_TOGC: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_TOGC) |=> (flags_out[DW-4] != $past(flags_in[DW-4]))
      && !flags_out[DW-2] && !flags_out[DW-3]); // R4

  AST_SPADD_ZN: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op_sel == OP_SPADD) |=> !flags_out[DW-1] && !flags_out[DW-2]); // R6

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc_out) && $stable(wide_out) && $stable(flags_out)); // R8

  AST_UNUSED_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel > OP_SPADD) |=> $stable(acc_out) && $stable(wide_out)
      && $stable(flags_out)); // R10

  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel != OP_SPADD) |=> $stable(wide_out)); // R11

endmodule

bind cpu_flag_unit flgu_chk #(.DW(DW), .AW(AW)) u_flgu_chk (.*);

// File: tb/cpu_flag_unit_test.sv
module cpu_flag_unit_test;

  typedef struct packed {
    logic [2:0]  op;
    logic [7:0]  a;
    logic [7:0]  b;
    logic [15:0] sp;
    logic [7:0]  f;
    logic [7:0]  ea;
    logic [15:0] ew;
    logic [7:0]  ef;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{3'd0, 8'h00, 8'h00, 16'h1234, 8'hF0, 8'h00, 16'h0000, 8'h80},
    '{3'd0, 8'h5A, 8'h81, 16'h1234, 8'hF0, 8'hDB, 16'h0000, 8'h00},
    '{3'd1, 8'h5A, 8'h00, 16'h0000, 8'h90, 8'hA5, 16'h0000, 8'hF0},
    '{3'd1, 8'hFF, 8'h00, 16'h0000, 8'h0F, 8'h00, 16'h0000, 8'h60},
    '{3'd2, 8'h33, 8'h00, 16'h0000, 8'hE0, 8'h33, 16'h0000, 8'h90},
    '{3'd3, 8'h44, 8'h00, 16'h0000, 8'h10, 8'h44, 16'h0000, 8'h00},
    '{3'd3, 8'h12, 8'h00, 16'h0000, 8'hF0, 8'h12, 16'h0000, 8'h80},
    '{3'd4, 8'h77, 8'hFF, 16'h1000, 8'hF0, 8'h77, 16'h0FFF, 8'h00},
    '{3'd4, 8'h78, 8'h08, 16'hFFF8, 8'h00, 8'h78, 16'h0000, 8'h30},
    '{3'd4, 8'h79, 8'h80, 16'h00FF, 8'h00, 8'h79, 16'h007F, 8'h10},
    '{3'd4, 8'h7A, 8'h01, 16'h000F, 8'h00, 8'h7A, 16'h0010, 8'h20},
    '{3'd0, 8'h00, 8'h01, 16'hFFFF, 8'h00, 8'h01, 16'h0010, 8'h00}
  };

  logic        clk;
  logic        rst_n;
  logic        en;
  logic [2:0]  op_sel;
  logic [7:0]  acc_in;
  logic [7:0]  operand;
  logic [15:0] sp_in;
  logic [7:0]  flags_in;
  logic [7:0]  acc_out;
  logic [15:0] wide_out;
  logic [7:0]  flags_out;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  cpu_flag_unit uut (
    .clk (clk), .rst_n (rst_n), .en (en), .op_sel (op_sel),
    .acc_in (acc_in), .operand (operand), .sp_in (sp_in),
    .flags_in (flags_in), .acc_out (acc_out), .wide_out (wide_out),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R1";
      3'd1:    return "R2";
      3'd2:    return "R3";
      3'd3:    return "R4";
      default: return "R5/R6";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; op_sel = 3'd0; acc_in = 8'h00;
    operand = 8'h00; sp_in = 16'h0000; flags_in = 8'h00;
    #1;
    chk("R9", "acc after reset", {8'h00, acc_out}, 16'h0000);
    chk("R9", "wide after reset", wide_out, 16'h0000);
    chk("R9", "flags after reset", {8'h00, flags_out}, 16'h0000);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      en = 1'b1; op_sel = VEC[i].op; acc_in = VEC[i].a; operand = VEC[i].b;
      sp_in = VEC[i].sp; flags_in = VEC[i].f;
      step();
      chk(tag_of(VEC[i].op), $sformatf("acc v%0d", i), {8'h00, acc_out}, {8'h00, VEC[i].ea});
      chk((VEC[i].op == 3'd4) ? "R5" : "R11", $sformatf("wide v%0d", i), wide_out, VEC[i].ew);
      chk(tag_of(VEC[i].op), $sformatf("flags v%0d", i), {8'h00, flags_out}, {8'h00, VEC[i].ef});
      chk("R7", $sformatf("low nibble v%0d", i), {12'h000, flags_out[3:0]}, 16'h0000);
    end

    // R8: enable low, disturbing inputs
    en = 1'b0; op_sel = 3'd4; acc_in = 8'hC3; operand = 8'h7F;
    sp_in = 16'h8000; flags_in = 8'hF0;
    step();
    chk("R8", "acc held", {8'h00, acc_out}, 16'h0001);
    chk("R8", "wide held", wide_out, 16'h0010);
    chk("R8", "flags held", {8'h00, flags_out}, 16'h0000);

    // R10: unused operation codes with enable high
    for (int c = 5; c < 8; c++) begin
      en = 1'b1; op_sel = 3'(c); acc_in = 8'hEE; flags_in = 8'hF0;
      step();
      chk("R10", $sformatf("acc code %0d", c), {8'h00, acc_out}, 16'h0001);
      chk("R10", $sformatf("wide code %0d", c), wide_out, 16'h0010);
      chk("R10", $sformatf("flags code %0d", c), {8'h00, flags_out}, 16'h0000);
    end

    // R3 with all input flag bits high, low nibble must stay zero (R7)
    en = 1'b1; op_sel = 3'd2; acc_in = 8'h0F; flags_in = 8'hFF;
    step();
    chk("R3", "set carry flags", {8'h00, flags_out}, 16'h0090);
    chk("R7", "low nibble from FF input", {12'h000, flags_out[3:0]}, 16'h0000);

    // R9: reset asserted mid-run clears at once
    en = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R9", "acc async clear", {8'h00, acc_out}, 16'h0000);
    chk("R9", "wide async clear", wide_out, 16'h0000);
    chk("R9", "flags async clear", {8'h00, flags_out}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule